// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer whose producer and consumer run on separate, unrelated clocks. Words are pushed on the write clock and popped on the read clock, and both sides may operate in the same period. Four active-low status outputs report the fill level. Empty and almost-empty belong to the read side. Full and almost-full belong to the write side. Read data leaves through an output register, and an output-enable input gates it.

The almost-empty and almost-full thresholds are held in two offset registers. A reset loads both with a default value. One write-side pin has two possible roles, chosen by a parameter. It can act as a second write enable, or it can act as a load select. When the pin works as a load select and is held low, write strobes update the offset registers instead of the memory. Read strobes in that state return the offset register contents on the data output. Both sides step through the two registers in a fixed order: the almost-empty offset first, then the almost-full offset, and then back again.

Pointers cross between the clock domains in Gray code through two-flop synchronisers. Each flag is registered in the domain that owns it.

Top module: `dcfifo_pflag`

## Requirements
- R1: A word on `wr_data` is stored at a rising `wclk` edge only when `wr_en_n` is 0, `wr_en2_ld` is 1 and `full_n` is 1. A write attempted while `full_n` is 0 is discarded.
- R2: A word is popped at a rising `rclk` edge only when `rd_en_a_n` and `rd_en_b_n` are both 0 and `empty_n` is 1. In every other case the output register keeps its value. This includes a single enable low and a read attempted while empty.
- R3: Words are returned in the order in which they were written, without loss, including across a completely full buffer.
- R4: Reset (`rst_n` = 0) sets the following state:
  - `empty_n` = 0, `aempty_n` = 0, `full_n` = 1, `afull_n` = 1.
  - The output register is cleared to 0.
  - Both offset registers are set to 7.
  - Both access positions select the almost-empty offset.
- R5: `full_n` is 0 exactly while 2^AW words (256 by default) are stored. `empty_n` is 0 once the stored count is 0, after synchronisation.
- R6: Once the pointers have settled, `aempty_n` is 0 while the stored count is at most the almost-empty offset, and 1 otherwise.
- R7: Once the pointers have settled, `afull_n` is 1 while the number of free locations is greater than the almost-full offset, and 0 otherwise.
- R8: With `wr_en2_ld` = 0, each `wclk` edge with `wr_en_n` = 0 writes `wr_data[AW-1:0]` into an offset register instead of the memory. Successive loads go to the almost-empty offset first and then the almost-full offset, wrapping after the second.
- R9: With `wr_en2_ld` = 0, each read strobe (both read enables 0) places the selected offset, zero-extended, in the output register. The selection follows the same order and wrap as loads, does not depend on the empty state, and does not move the read pointer.
- R10: `rd_data` equals the output register while `rd_oe` is 1, and is all zeros while `rd_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock, unrelated to wclk |
| rst_n | input | 1 | Asynchronous reset, active low, for both domains |
| wr_en_n | input | 1 | Write strobe, active low |
| wr_en2_ld | input | 1 | Second write enable (high) or, when configured, load select (low) |
| wr_data | input | DW (9) | Write data, or offset value during load |
| rd_en_a_n | input | 1 | First read enable, active low |
| rd_en_b_n | input | 1 | Second read enable, active low |
| rd_oe | input | 1 | Output enable for rd_data |
| rd_data | output | DW (9) | Registered read data, zero while disabled |
| empty_n | output | 1 | Empty flag, active low, read domain |
| full_n | output | 1 | Full flag, active low, write domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read domain |
| afull_n | output | 1 | Almost-full flag, active low, write domain |

## Verification
The ordering path is exercised with a short burst of three words and with a fill to full depth followed by overrun writes. The first pattern checks basic ordering. The second separates correct full gating from silent overwrite of the oldest data. Threshold behaviour is probed at one word on either side of each boundary, under both the default offsets and reprogrammed ones. This catches off-by-one errors in the comparisons. Reads with only one enable low, and reads while empty, show that the output register holds its value. A load sequence of three writes and three readbacks shows the access order and its wrap, and shows that loads never reach the data memory.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
   typedef enum logic {SEL_AE = 1'b0, SEL_AF = 1'b1} off_sel_e;
endpackage

// File: rtl/dcf_gsync.sv
module dcf_gsync #(
   parameter int PW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] gray_i,
   output logic [PW-1:0] bin_o
);
   logic [PW-1:0] s1, s2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= '0;
         s2 <= '0;
      end else begin
         s1 <= gray_i;
         s2 <= s1;
      end
   end

   // Gray to binary: running XOR from the top bit down
   always_comb begin
      logic acc;
      acc = 1'b0;
      for (int i = PW - 1; i >= 0; i--) begin
         acc      = acc ^ s2[i];
         bin_o[i] = acc;
      end
   end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
   parameter int DW = 9,
   parameter int AW = 8
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wside.sv
module dcf_wside
   import dcf_pkg::*;
#(
   parameter int AW           = 8,
   parameter bit PIN2_IS_LOAD = 1'b1,
   parameter int OFF_RST      = 7
) (
   input  logic          wclk,
   input  logic          rst_n,
   input  logic          wr_en_n,
   input  logic          wr_en2_ld,
   input  logic [AW-1:0] off_din,
   input  logic [AW:0]   rbin_s,
   output logic          wr_fire,
   output logic [AW:0]   wbin,
   output logic [AW:0]   wgray,
   output logic [AW-1:0] ae_off,
   output logic [AW-1:0] af_off,
   output logic          full_n,
   output logic          afull_n
);
   localparam logic [AW:0] DEPTH_V = (AW+1)'(1) << AW;

   logic      data_req, load_req;
   off_sel_e  wsel;
   logic [AW:0] wbin_nx, wcnt_nx, free_nx, wcnt_cur;

   if (PIN2_IS_LOAD) begin : g_load
      assign data_req = !wr_en_n && wr_en2_ld;
      assign load_req = !wr_en_n && !wr_en2_ld;
   end else begin : g_dual_we
      assign data_req = !wr_en_n && wr_en2_ld;
      assign load_req = 1'b0;
   end

   assign wr_fire  = data_req && full_n;
   assign wbin_nx  = wbin + {{AW{1'b0}}, wr_fire};
   assign wcnt_nx  = wbin_nx - rbin_s;
   assign free_nx  = DEPTH_V - wcnt_nx;
   assign wcnt_cur = wbin - rbin_s;

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wbin    <= '0;
         wgray   <= '0;
         full_n  <= 1'b1;
         afull_n <= 1'b1;
      end else begin
         wbin    <= wbin_nx;
         wgray   <= wbin_nx ^ (wbin_nx >> 1);
         full_n  <= (wcnt_nx != DEPTH_V);
         afull_n <= (free_nx > {1'b0, af_off});
      end
   end

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         ae_off <= AW'(OFF_RST);
         af_off <= AW'(OFF_RST);
         wsel   <= SEL_AE;
      end else if (load_req) begin
         if (wsel == SEL_AE) ae_off <= off_din;
         else                af_off <= off_din;
         wsel <= (wsel == SEL_AE) ? SEL_AF : SEL_AE;
      end
   end

   // R1
   full_hold_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      !full_n |=> $stable(wbin));
   // R7
   full_af_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      !full_n |-> !afull_n);
   // R8
   seq_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      load_req |=> (wsel != $past(wsel)));
   // R5
   always_ff @(posedge wclk) begin
      if (rst_n) count_range_chk: assert (wcnt_cur <= DEPTH_V);
   end
endmodule

// File: rtl/dcf_rside.sv
module dcf_rside
   import dcf_pkg::*;
#(
   parameter int DW = 9,
   parameter int AW = 8
) (
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          rd_en_a_n,
   input  logic          rd_en_b_n,
   input  logic          ld_rd,
   input  logic [AW:0]   wbin_s,
   input  logic [AW-1:0] ae_off,
   input  logic [AW-1:0] af_off,
   input  logic [DW-1:0] ram_q,
   output logic [AW:0]   rbin,
   output logic [AW:0]   rgray,
   output logic [DW-1:0] q,
   output logic          empty_n,
   output logic          aempty_n
);
   logic        rd_req, rd_fire, off_fire;
   off_sel_e    rsel;
   logic [AW:0] rbin_nx, rcnt_nx;

   assign rd_req   = !rd_en_a_n && !rd_en_b_n;
   assign off_fire = rd_req && ld_rd;
   assign rd_fire  = rd_req && !ld_rd && empty_n;
   assign rbin_nx  = rbin + {{AW{1'b0}}, rd_fire};
   assign rcnt_nx  = wbin_s - rbin_nx;

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rbin     <= '0;
         rgray    <= '0;
         empty_n  <= 1'b0;
         aempty_n <= 1'b0;
      end else begin
         rbin     <= rbin_nx;
         rgray    <= rbin_nx ^ (rbin_nx >> 1);
         empty_n  <= (rcnt_nx != '0);
         aempty_n <= (rcnt_nx > {1'b0, ae_off});
      end
   end

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         q    <= '0;
         rsel <= SEL_AE;
      end else if (off_fire) begin
         q    <= (rsel == SEL_AE) ? DW'(ae_off) : DW'(af_off);
         rsel <= (rsel == SEL_AE) ? SEL_AF : SEL_AE;
      end else if (rd_fire) begin
         q <= ram_q;
      end
   end

   // R2
   empty_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
      !empty_n |=> $stable(rbin));
   // R6
   empty_ae_chk: assert property (@(posedge rclk) disable iff (!rst_n)
      !empty_n |-> !aempty_n);
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
   parameter int DW           = 9,
   parameter int AW           = 8,
   parameter bit PIN2_IS_LOAD = 1'b1,
   parameter int OFF_RST      = 7
) (
   input  logic          wclk,
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          wr_en_n,
   input  logic          wr_en2_ld,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en_a_n,
   input  logic          rd_en_b_n,
   input  logic          rd_oe,
   output logic [DW-1:0] rd_data,
   output logic          empty_n,
   output logic          full_n,
   output logic          aempty_n,
   output logic          afull_n
);
   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;

   if (AW < 2 || AW > DW) begin : g_bad_aw
      $error("dcfifo_pflag: AW must lie in 2..DW so an offset fits one word");
   end
   if (OFF_RST < 0 || OFF_RST >= DEPTH) begin : g_bad_off
      $error("dcfifo_pflag: OFF_RST must lie below the depth");
   end

   logic          wr_fire, ld_rd;
   logic [PW-1:0] wbin, wgray, rbin, rgray, wbin_s, rbin_s;
   logic [AW-1:0] ae_off, af_off;
   logic [DW-1:0] ram_q, q;

   if (PIN2_IS_LOAD) begin : g_ldsync
      logic [1:0] ld_ff;
      always_ff @(posedge rclk or negedge rst_n) begin
         if (!rst_n) ld_ff <= '0;
         else        ld_ff <= {ld_ff[0], ~wr_en2_ld};
      end
      assign ld_rd = ld_ff[1];
   end else begin : g_noload
      assign ld_rd = 1'b0;
   end

   dcf_wside #(.AW(AW), .PIN2_IS_LOAD(PIN2_IS_LOAD), .OFF_RST(OFF_RST)) u_wside (
      .wclk(wclk), .rst_n(rst_n), .wr_en_n(wr_en_n), .wr_en2_ld(wr_en2_ld),
      .off_din(wr_data[AW-1:0]), .rbin_s(rbin_s), .wr_fire(wr_fire),
      .wbin(wbin), .wgray(wgray), .ae_off(ae_off), .af_off(af_off),
      .full_n(full_n), .afull_n(afull_n));

   dcf_gsync #(.PW(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .gray_i(rgray), .bin_o(rbin_s));
   dcf_gsync #(.PW(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .gray_i(wgray), .bin_o(wbin_s));

   dcf_ram #(.DW(DW), .AW(AW)) u_ram (
      .wclk(wclk), .we(wr_fire), .waddr(wbin[AW-1:0]), .wdata(wr_data),
      .raddr(rbin[AW-1:0]), .rdata(ram_q));

   dcf_rside #(.DW(DW), .AW(AW)) u_rside (
      .rclk(rclk), .rst_n(rst_n), .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n),
      .ld_rd(ld_rd), .wbin_s(wbin_s), .ae_off(ae_off), .af_off(af_off),
      .ram_q(ram_q), .rbin(rbin), .rgray(rgray), .q(q),
      .empty_n(empty_n), .aempty_n(aempty_n));

   assign rd_data = rd_oe ? q : '0;

   // R10
   always_comb begin
      if (!rd_oe) oe_gate_chk: assert (rd_data == '0);
   end
endmodule

// File: tb/dcfifo_pflag_tb.sv
module dcfifo_pflag_tb;
   localparam int DW = 9;
   localparam int DEPTH = 256;

   logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
   logic wr_en_n = 1'b1, wr_en2_ld = 1'b1, rd_en_a_n = 1'b1, rd_en_b_n = 1'b1, rd_oe = 1'b1;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic empty_n, full_n, aempty_n, afull_n;

   int total = 0, bad = 0;
   logic [DW-1:0] mq[$];
   logic [DW-1:0] exp_q = '0;

   always #4   wclk = ~wclk;
   always #5.5 rclk = ~rclk;

   dcfifo_pflag u_dut (
      .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en_n(wr_en_n), .wr_en2_ld(wr_en2_ld),
      .wr_data(wr_data), .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n), .rd_oe(rd_oe),
      .rd_data(rd_data), .empty_n(empty_n), .full_n(full_n), .aempty_n(aempty_n),
      .afull_n(afull_n));

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (8) @(negedge wclk);
      repeat (8) @(negedge rclk);
   endtask

   task automatic do_reset();
      @(negedge wclk);
      rst_n = 1'b0;
      #20;
      @(negedge wclk);
      #1 rst_n = 1'b1;
      mq.delete();
      exp_q = '0;
      settle();
   endtask

   task automatic wr_burst(input int n, input int seed);
      for (int i = 0; i < n; i++) begin
         @(negedge wclk);
         wr_data = DW'(seed + i * 37);
         wr_en_n = 1'b0;
         if (mq.size() < DEPTH) mq.push_back(wr_data);
      end
      @(negedge wclk);
      wr_en_n = 1'b1;
   endtask

   task automatic rd_burst(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge rclk);
         if (i > 0) chk(req, rd_data, exp_q);
         rd_en_a_n = 1'b0;
         rd_en_b_n = 1'b0;
         if (mq.size() > 0) exp_q = mq.pop_front();
      end
      @(negedge rclk);
      chk(req, rd_data, exp_q);
      rd_en_a_n = 1'b1;
      rd_en_b_n = 1'b1;
   endtask

   task automatic ld_write(input int v);
      @(negedge wclk);
      wr_data = DW'(v);
      wr_en_n = 1'b0;
      @(negedge wclk);
      wr_en_n = 1'b1;
   endtask

   task automatic ld_read(input int exp, input string req);
      @(negedge rclk);
      rd_en_a_n = 1'b0;
      rd_en_b_n = 1'b0;
      @(negedge rclk);
      rd_en_a_n = 1'b1;
      rd_en_b_n = 1'b1;
      chk(req, rd_data, exp);
      exp_q = DW'(exp);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R4 empty_n", empty_n, 0);
      chk("R4 aempty_n", aempty_n, 0);
      chk("R4 full_n", full_n, 1);
      chk("R4 afull_n", afull_n, 1);
      chk("R4 rd_data", rd_data, 0);
   endtask

   task automatic t_basic();
      wr_burst(3, 9'h1A5);
      settle();
      chk("R5 empty_n after writes", empty_n, 1);
      // R2: only one read enable low must not pop
      @(negedge rclk);
      rd_en_a_n = 1'b0;
      repeat (2) @(negedge rclk);
      rd_en_a_n = 1'b1;
      chk("R2 single enable holds", rd_data, exp_q);
      rd_burst(3, "R3 short burst order");
      settle();
      chk("R5 empty_n after drain", empty_n, 0);
   endtask

   task automatic t_ae_default();
      wr_burst(7, 9'h011);
      settle();
      chk("R6 count 7 at offset 7", aempty_n, 0);
      wr_burst(1, 9'h0F0);
      settle();
      chk("R6 count 8 above offset 7", aempty_n, 1);
      rd_burst(8, "R3 ae burst order");
      settle();
      chk("R6 drained aempty_n", aempty_n, 0);
   endtask

   task automatic t_full();
      wr_burst(DEPTH - 8, 9'h033);
      settle();
      chk("R7 free 8 above offset 7", afull_n, 1);
      wr_burst(1, 9'h155);
      settle();
      chk("R7 free 7 at offset 7", afull_n, 0);
      chk("R5 not full at 249", full_n, 1);
      wr_burst(7, 9'h0AA);
      chk("R5 full at depth", full_n, 0);
      wr_burst(3, 9'h1FF);   // R1: overrun writes, model drops them
      settle();
      chk("R1 still full after overrun", full_n, 0);
      rd_burst(DEPTH, "R1 R3 full drain order");
      rd_burst(2, "R2 read while empty holds");
      settle();
      chk("R5 empty after full drain", empty_n, 0);
      chk("R5 full_n released", full_n, 1);
      chk("R7 afull_n released", afull_n, 1);
   endtask

   task automatic t_load();
      wr_en2_ld = 1'b0;
      settle();
      ld_write(4);
      ld_write(5);
      ld_write(3);           // R8 wrap: overwrites the almost-empty offset
      settle();
      chk("R8 load does not store data", empty_n, 0);
      ld_read(3, "R9 readback ae offset");
      ld_read(5, "R9 readback af offset");
      ld_read(3, "R9 readback wrap");
      chk("R9 readback leaves empty", empty_n, 0);
      wr_en2_ld = 1'b1;
      settle();
      wr_burst(3, 9'h077);
      settle();
      chk("R6 count 3 at offset 3", aempty_n, 0);
      wr_burst(1, 9'h101);
      settle();
      chk("R6 count 4 above offset 3", aempty_n, 1);
      wr_burst(DEPTH - 10, 9'h021);
      settle();
      chk("R7 free 6 above offset 5", afull_n, 1);
      wr_burst(1, 9'h0C3);
      settle();
      chk("R7 free 5 at offset 5", afull_n, 0);
      rd_burst(DEPTH - 5, "R3 drain after load");
      settle();
      chk("R5 empty after load drain", empty_n, 0);
   endtask

   task automatic t_oe();
      wr_burst(1, 9'h1C7);
      settle();
      rd_burst(1, "R3 oe word");
      rd_oe = 1'b0;
      #1;
      chk("R10 oe low gives zero", rd_data, 0);
      rd_oe = 1'b1;
      #1;
      chk("R10 oe high restores", rd_data, 9'h1C7);
   endtask

   task automatic t_reset_offsets();
      do_reset();
      wr_en2_ld = 1'b0;
      settle();
      ld_read(7, "R4 ae offset default");
      ld_read(7, "R4 af offset default");
      wr_en2_ld = 1'b1;
      settle();
   endtask

   initial begin
      #2_000_000;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_basic();
      t_ae_default();
      t_full();
      t_load();
      t_oe();
      t_reset_offsets();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule